// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits after an HDLC deframer. It receives de-stuffed frame bytes on a ready/valid stream. The first byte of a frame carries a start strobe and the last byte carries an end strobe together with the frame's error status. The filter takes the first one or two bytes of each frame as the station address. It compares that address against four programmable 16-bit slots, using one shared bit-enable mask. A frame that hits any slot leaves the block unchanged, address bytes included. A frame that hits no slot is swallowed whole.

The mask also selects the address width. When its upper byte is all zero, the decision is made on the first byte alone. Otherwise the first byte is held inside the block until the second byte arrives and the full 16-bit compare has resolved. Dropped frames that end without error are counted in a saturating 16-bit counter, which a synchronous input can clear. A typical setup puts one station address in one slot and the all-ones broadcast address in another.

Top module: `hdlc_addr_filter`

## Requirements
- R1: After reset `out_valid` is 0 and `miss_count` is 0.
- R2: In 16-bit mode the compare value is {second byte, first byte}: the first byte after the start strobe sits in bits 7:0 and the second in bits 15:8. For example, bytes 0x68 then 0xAA hit a slot holding 0xAA68 under mask 0xFFFF. The first byte is withheld until the second byte is present, and is then emitted with the start strobe set and the end strobe clear.
- R3: A mask bit at 1 makes that address bit take part in the compare. A mask bit at 0 makes that bit a don't-care for all four slots.
- R4: When mask bits 15:8 are all 0, the block works in 8-bit mode: only the first byte (bits 7:0) is compared, and a single-byte frame can be accepted.
- R5: A frame whose address hits any of the four slots appears at the output byte for byte: the same data, the start strobe on the first byte, and the end strobe and error bit on the last byte.
- R6: A frame whose address hits no slot produces no output byte at all.
- R7: A dropped frame whose end byte has the error bit at 0 raises `miss_count` by exactly 1. A dropped frame with the error bit at 1 leaves the count unchanged.
- R8: In 16-bit mode, a frame that ends on its first byte is treated as a nonmatch and counted under R7.
- R9: `miss_count` holds at 0xFFFF and does not wrap.
- R10: `miss_clr` sets `miss_count` to 0 on the next clock, and takes priority over an increment in the same cycle.
- R11: While a frame is being forwarded, `in_ready` equals `out_ready`, and a stalled output loses and repeats no byte. While `in_valid` is 0, no byte is produced.
- R12: Bytes that arrive outside a frame without a start strobe are accepted and discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take the input byte |
| in_data | input | 8 | De-stuffed frame byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_err | input | 1 | Frame error status, meaningful with in_eof |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream can take the output byte |
| out_data | output | 8 | Forwarded frame byte |
| out_sof | output | 1 | First byte of a forwarded frame |
| out_eof | output | 1 | Last byte of a forwarded frame |
| out_err | output | 1 | Error status of a forwarded frame |
| slot_addrs | input | 64 | Four 16-bit address slots; slot n in bits 16n+15:16n |
| addr_mask | input | 16 | Bit-enable mask for the compare |
| miss_clr | input | 1 | Synchronous clear of the miss counter |
| miss_count | output | 16 | Count of error-free dropped frames |

## Verification
The properties assume a well-formed input stream. Every frame opens with a start strobe, closes with exactly one end strobe, and carries no start strobe in between. A byte that is offered but not yet accepted stays unchanged. The slots and the mask change only while no frame is in progress. The stimulus keeps within these limits: a single task offers each frame byte by byte and holds every byte until it is taken, and the configuration is rewritten only after the input has gone idle. Output backpressure is the one thing left free. A pseudo-random `out_ready` pattern drives it in the later part of the run.

// File: rtl/hdlc_af_pkg.sv
package hdlc_af_pkg;

  localparam int AF_BYTE_W = 8;
  localparam int AF_ADDR_W = 2 * AF_BYTE_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,   // waiting for a start strobe
    ST_HOLD = 2'd1,   // first address byte captured, waiting for the second
    ST_PASS = 2'd2,   // frame accepted, bytes flow through
    ST_DROP = 2'd3    // frame rejected, bytes swallowed
  } af_state_e;

  // A slot agrees with the address when no enabled bit differs.
  function automatic logic slot_agrees(input logic [AF_ADDR_W-1:0] addr,
                                       input logic [AF_ADDR_W-1:0] slot,
                                       input logic [AF_ADDR_W-1:0] mask);
    return ((addr ^ slot) & mask) == '0;
  endfunction

  // The short address form is chosen by an all-zero upper mask byte.
  function automatic logic mask_is_short(input logic [AF_ADDR_W-1:0] mask);
    return mask[AF_ADDR_W-1:AF_BYTE_W] == '0;
  endfunction

  // Compare value: first byte low, current byte high once both exist.
  function automatic logic [AF_ADDR_W-1:0] build_addr(input logic two_bytes,
                                                      input logic [AF_BYTE_W-1:0] first,
                                                      input logic [AF_BYTE_W-1:0] cur);
    return two_bytes ? {cur, first} : {{AF_BYTE_W{1'b0}}, cur};
  endfunction

endpackage

// File: rtl/af_addr_match.sv
module af_addr_match
  import hdlc_af_pkg::*;
#(
  parameter int NSLOT = 4
) (
  input  logic [AF_ADDR_W-1:0]       addr,
  input  logic [NSLOT*AF_ADDR_W-1:0] slots,
  input  logic [AF_ADDR_W-1:0]       mask,
  output logic [NSLOT-1:0]           slot_hit,
  output logic                       any_hit
);

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign slot_hit[g] = slot_agrees(addr, slots[g*AF_ADDR_W +: AF_ADDR_W], mask);
  end

  assign any_hit = |slot_hit;

endmodule

// File: rtl/af_miss_counter.sv
module af_miss_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count
);

  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic at_top;
  assign at_top = &count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (inc && !at_top) begin
      count <= count + ONE;
    end
  end

endmodule

// File: rtl/af_frame_ctrl.sv
module af_frame_ctrl
  import hdlc_af_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [AF_BYTE_W-1:0] in_data,
  input  logic                 in_sof,
  input  logic                 in_eof,
  input  logic                 in_err,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [AF_BYTE_W-1:0] out_data,
  output logic                 out_sof,
  output logic                 out_eof,
  output logic                 out_err,
  input  logic                 short_mode,
  input  logic                 any_hit,
  output logic [AF_ADDR_W-1:0] cmp_addr,
  output logic                 miss_event,
  output logic                 in_drop,
  output logic                 hold_emit
);

  af_state_e              state_q, state_d;
  logic [AF_BYTE_W-1:0]   hold_q;
  logic                   hold_load;
  logic                   accept;

  assign cmp_addr = build_addr(state_q == ST_HOLD, hold_q, in_data);
  assign in_drop  = (state_q == ST_DROP);

  // Output side and input ready.
  always_comb begin
    out_valid = 1'b0;
    out_data  = in_data;
    out_sof   = in_sof;
    out_eof   = in_eof;
    out_err   = in_err;
    in_ready  = 1'b1;
    hold_emit = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (in_valid && in_sof && short_mode && any_hit) begin
          out_valid = 1'b1;
          in_ready  = out_ready;
        end
      end
      ST_HOLD: begin
        if (in_valid && any_hit) begin
          hold_emit = 1'b1;
          out_valid = 1'b1;
          out_data  = hold_q;
          out_sof   = 1'b1;
          out_eof   = 1'b0;
          out_err   = 1'b0;
          in_ready  = 1'b0;
        end
      end
      ST_PASS: begin
        out_valid = in_valid;
        in_ready  = out_ready;
      end
      default: ;
    endcase
  end

  assign accept = in_valid && in_ready;

  // Frame sequencing and miss detection.
  always_comb begin
    state_d    = state_q;
    miss_event = 1'b0;
    hold_load  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept && in_sof) begin
          if (short_mode) begin
            if (any_hit) begin
              state_d = in_eof ? ST_IDLE : ST_PASS;
            end else if (in_eof) begin
              miss_event = !in_err;
            end else begin
              state_d = ST_DROP;
            end
          end else if (in_eof) begin
            miss_event = !in_err;
          end else begin
            hold_load = 1'b1;
            state_d   = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (hold_emit) begin
          if (out_ready) state_d = ST_PASS;
        end else if (accept) begin
          if (in_eof) begin
            miss_event = !in_err;
            state_d    = ST_IDLE;
          end else begin
            state_d = ST_DROP;
          end
        end
      end
      ST_PASS: begin
        if (accept && in_eof) state_d = ST_IDLE;
      end
      ST_DROP: begin
        if (accept && in_eof) begin
          miss_event = !in_err;
          state_d    = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      if (hold_load) hold_q <= in_data;
    end
  end

endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
  import hdlc_af_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int CW    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [AF_BYTE_W-1:0]       in_data,
  input  logic                       in_sof,
  input  logic                       in_eof,
  input  logic                       in_err,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [AF_BYTE_W-1:0]       out_data,
  output logic                       out_sof,
  output logic                       out_eof,
  output logic                       out_err,
  input  logic [NSLOT*AF_ADDR_W-1:0] slot_addrs,
  input  logic [AF_ADDR_W-1:0]       addr_mask,
  input  logic                       miss_clr,
  output logic [CW-1:0]              miss_count
);

  // Named internal events, observed by the bound checker.
  logic                 short_mode;
  logic                 any_hit;
  logic [NSLOT-1:0]     slot_hit;
  logic [AF_ADDR_W-1:0] cmp_addr;
  logic                 miss_event;
  logic                 in_drop;
  logic                 hold_emit;

  assign short_mode = mask_is_short(addr_mask);

  af_addr_match #(.NSLOT(NSLOT)) u_match (
    .addr     (cmp_addr),
    .slots    (slot_addrs),
    .mask     (addr_mask),
    .slot_hit (slot_hit),
    .any_hit  (any_hit)
  );

  af_frame_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .in_sof     (in_sof),
    .in_eof     (in_eof),
    .in_err     (in_err),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_sof    (out_sof),
    .out_eof    (out_eof),
    .out_err    (out_err),
    .short_mode (short_mode),
    .any_hit    (any_hit),
    .cmp_addr   (cmp_addr),
    .miss_event (miss_event),
    .in_drop    (in_drop),
    .hold_emit  (hold_emit)
  );

  af_miss_counter #(.CW(CW)) u_miss (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (miss_clr),
    .inc   (miss_event),
    .count (miss_count)
  );

endmodule

// File: rtl/af_filter_checker.sv
module af_filter_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_sof,
  input logic          out_eof,
  input logic          miss_clr,
  input logic          miss_event,
  input logic          in_drop,
  input logic          hold_emit,
  input logic [CW-1:0] miss_count
);

  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    miss_clr |=> (miss_count == '0));

  p_saturate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((&miss_count) && !miss_clr) |=> (&miss_count));

  p_quiet_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!miss_clr && !miss_event) |=> $stable(miss_count));

  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_event && !miss_clr && !(&miss_count)) |=> (miss_count == $past(miss_count) + ONE));

  p_drop_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_drop |-> !out_valid);

  p_ready_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !hold_emit) |-> (in_ready == out_ready));

  p_no_invent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !out_valid);

  p_hold_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hold_emit |-> (out_sof && !out_eof && !in_ready));

endmodule

bind hdlc_addr_filter af_filter_checker #(.CW(CW)) u_af_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_sof    (out_sof),
  .out_eof    (out_eof),
  .miss_clr   (miss_clr),
  .miss_event (miss_event),
  .in_drop    (in_drop),
  .hold_emit  (hold_emit),
  .miss_count (miss_count)
);

// File: tb/tb_hdlc_addr_filter.sv
module tb_hdlc_addr_filter;

  localparam int CLK_PERIOD = 10;
  localparam int NSLOT      = 4;
  localparam int CW         = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_sof, in_eof, in_err;
  logic [7:0]  in_data;
  logic        out_valid, out_ready, out_sof, out_eof, out_err;
  logic [7:0]  out_data;
  logic [63:0] slots;
  logic [15:0] mask;
  logic        miss_clr;
  logic [15:0] miss_count;

  hdlc_addr_filter #(.NSLOT(NSLOT), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_err(in_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .out_err(out_err),
    .slot_addrs(slots), .addr_mask(mask),
    .miss_clr(miss_clr), .miss_count(miss_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [7:0] d;
    logic       s;
    logic       e;
    logic       r;
  } obyte_t;

  int         errors = 0;
  int         checks = 0;
  int         model_cnt = 0;
  obyte_t     expq[$];
  obyte_t     head;
  logic [7:0] frm[$];
  string      tag = "R1";
  bit         started = 0;
  bit         bp_en = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference decision, bit by bit over the slots.
  function automatic bit exp_hit(input logic [7:0] b0, input logic [7:0] b1, input int n);
    bit eight = (mask[15:8] == 8'h00);
    if (!eight && n < 2) return 0;
    for (int s = 0; s < NSLOT; s++) begin
      bit ok = 1;
      for (int k = 0; k < 16; k++) begin
        logic ab = (k < 8) ? b0[k] : b1[k-8];
        if (mask[k] && (ab !== slots[s*16+k])) ok = 0;
      end
      if (ok) return 1;
    end
    return 0;
  endfunction

  // Downstream readiness.
  always @(negedge clk) begin
    out_ready = bp_en ? (lfsr[0] | lfsr[3]) : 1'b1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  // Per-cycle comparison against the reference.
  always @(negedge clk) begin
    if (rst_n && started) begin
      #2;
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check(0, "R6", "unexpected output byte", int'(out_data), 0);
        end else begin
          head = expq.pop_front();
          check(out_data == head.d && out_sof == head.s && out_eof == head.e && out_err == head.r,
                tag, "output byte {sof,eof,err,data}",
                int'({out_sof, out_eof, out_err, out_data}),
                int'({head.s, head.e, head.r, head.d}));
        end
      end
      check(int'(miss_count) == model_cnt, tag, "miss_count", int'(miss_count), model_cnt);
    end
  end

  task automatic offer(input logic [7:0] d, input bit sof, input bit eof,
                       input bit err, input bit clr);
    bit acc = 0;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sof = sof; in_eof = eof;
    in_err = err; miss_clr = clr;
    while (!acc) begin
      #1;
      acc = in_ready;
      @(posedge clk);
      if (!acc) @(negedge clk);
    end
  endtask

  task automatic send_frame(input bit err, input bit clr_end);
    int n = frm.size();
    bit hit = exp_hit(frm[0], (n > 1) ? frm[1] : 8'h00, n);
    if (hit) begin
      for (int i = 0; i < n; i++)
        expq.push_back('{d: frm[i], s: (i == 0), e: (i == n-1), r: (i == n-1) && err});
    end
    for (int i = 0; i < n; i++) begin
      bit last = (i == n-1);
      offer(frm[i], i == 0, last, err && last, clr_end && last);
      if (last) begin
        if (clr_end) model_cnt = 0;
        else if (!hit && !err && model_cnt < 16'hFFFF) model_cnt++;
      end
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0; miss_clr = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00; in_sof = 1'b0; in_eof = 1'b0;
    in_err = 1'b0; miss_clr = 1'b0;
    slots = {16'hBEEF, 16'h1234, 16'hFFFF, 16'hAA68};
    mask  = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #3;
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(miss_count == 16'h0, "R1", "miss_count after reset", int'(miss_count), 0);
    started = 1;

    tag = "R2";  frm = '{8'h68, 8'hAA, 8'h44, 8'h11};  send_frame(0, 0); idle(2);
    tag = "R2";  frm = '{8'hAA, 8'h68, 8'h44};         send_frame(0, 0); idle(2);
    tag = "R5";  frm = '{8'hFF, 8'hFF, 8'h03};         send_frame(1, 0); idle(2);
    tag = "R5";  frm = '{8'h34, 8'h12, 8'h99, 8'h00, 8'h7E}; send_frame(0, 0); idle(2);
    tag = "R7";  frm = '{8'h01, 8'h02, 8'h03};         send_frame(1, 0); idle(2);
    tag = "R6";  frm = '{8'h11, 8'h22, 8'h33, 8'h44};  send_frame(0, 0); idle(2);
    tag = "R8";  frm = '{8'h68};                       send_frame(0, 0); idle(2);
    tag = "R12"; offer(8'h68, 0, 0, 0, 0); offer(8'hAA, 0, 1, 0, 0); idle(2);
    tag = "R12"; frm = '{8'hEF, 8'hBE, 8'h05};         send_frame(0, 0); idle(2);

    mask = 16'hF0FF;
    tag = "R3";  frm = '{8'h68, 8'hA3, 8'h10};         send_frame(0, 0); idle(2);
    tag = "R3";  frm = '{8'h68, 8'hBA, 8'h10};         send_frame(0, 0); idle(2);

    mask = 16'h00FF;
    tag = "R4";  frm = '{8'h68, 8'h01, 8'h02};         send_frame(0, 0); idle(2);
    tag = "R4";  frm = '{8'h34};                       send_frame(1, 0); idle(2);
    tag = "R4";  frm = '{8'h56};                       send_frame(0, 0); idle(2);
    tag = "R7";  frm = '{8'h56, 8'h00};                send_frame(1, 0); idle(2);

    mask = 16'hFFFF;
    bp_en = 1;
    tag = "R11";
    for (int f = 0; f < 6; f++) begin
      frm = '{8'h68, 8'hAA};
      for (int b = 0; b < 6 + f; b++) frm.push_back(8'(b * 17 + f));
      send_frame(f[0], 0);
      frm = '{8'hFF, 8'hFF, 8'(f)};
      send_frame(0, 0);
      frm = '{8'h00, 8'h01, 8'h02};
      send_frame(0, 0);
    end
    idle(30);
    bp_en = 0;
    idle(4);

    tag = "R9";
    for (int i = 0; i < 65539; i++) begin
      frm = '{8'h00};
      send_frame(0, 0);
    end
    idle(3);
    check(miss_count == 16'hFFFF, "R9", "miss_count saturated", int'(miss_count), 16'hFFFF);

    tag = "R10"; frm = '{8'h00}; send_frame(0, 1); idle(3);
    check(miss_count == 16'h0, "R10", "clear beats increment", int'(miss_count), 0);

    idle(10);
    check(expq.size() == 0, "R5", "expected bytes left undelivered", expq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule